// File: doc/BRIEF.md
# Two-Cell Overdischarge Guard with Sleep and Charger Wake

This block is the digital decision logic that protects a series pair of cells from being drained too far. Analog comparators outside the block report, per cell, whether the voltage sits below the overdischarge detection level and whether it sits below the higher resume level. A charger-present flag and per-cell overcharge flags complete the inputs. The block asserts discharge-enable while the pack is healthy. It removes discharge only when a low cell persists for a fixed number of clock cycles. It then raises a power-down request that turns off overcurrent monitoring.

While asleep, the block tells the comparators to use the resume level instead of the detection level. It restores discharge on its own only once no cell is below that higher level. A charger that appears during sleep wakes the block and returns it to the detection level. Discharge then comes back as soon as both cells are above the detection level. Overcharge monitoring stays powered in sleep whenever either cell reports overcharge.

The delay is the parameter `DLY_CYCLES`, given in clock cycles, and it must be 2 or more. At 50 MHz the default of 750000 gives 15 ms. `NCELL` sets the number of cells and defaults to 2.

Top module: `odd_guard`

## Requirements
- R1: After reset, dsg_en=1, pwr_down=0, thr_res=0 (0 selects the detection level, 1 selects the resume level), ocp_mon_en=1 and ovc_mon_en=1.
- R2: If any bit of cell_lo_det is 1 at DLY_CYCLES consecutive rising edges, dsg_en falls after the last of those edges and not before it.
- R3: If cell_lo_det returns to all zero before the delay completes, the count is discarded and dsg_en stays 1. A later low event needs a full DLY_CYCLES edges again.
- R4: In sleep, pwr_down=1, thr_res=1, dsg_en=0 and ocp_mon_en=0.
- R5: In sleep, ovc_mon_en equals the OR of the cell_hi_chg bits. Outside sleep, ovc_mon_en is 1.
- R6: In sleep, the block returns to normal operation (dsg_en=1, pwr_down=0, thr_res=0) one edge after cell_lo_res is sampled all zero. While any cell_lo_res bit is 1 and no charger is present, it stays asleep whatever cell_lo_det shows.
- R7: In sleep, chg_present=1 while some cell_lo_res bit is 1 moves the block to a wake state after one edge: pwr_down=0, thr_res=0, dsg_en=0, ocp_mon_en=1, ovc_mon_en=1.
- R8: In the wake state, cell_lo_det sampled all zero restores normal operation with dsg_en=1. If chg_present drops while some cell_lo_det bit is 1, the block goes back to sleep.
- R9: In normal operation, cell_lo_res, chg_present and cell_hi_chg have no effect on any output.
- R10: A low flag on either cell alone, bit 0 or bit 1, starts the delay.
- R11: In sleep, an all-zero cell_lo_res takes priority over chg_present, so the block goes straight to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cell_lo_det | input | NCELL | Per cell: 1 when the voltage is below the detection level |
| cell_lo_res | input | NCELL | Per cell: 1 when the voltage is below the resume level |
| cell_hi_chg | input | NCELL | Per cell: 1 when the cell reports overcharge |
| chg_present | input | 1 | Charger attached |
| dsg_en | output | 1 | Discharge switch enable |
| pwr_down | output | 1 | Low-power request to the analog side |
| thr_res | output | 1 | Threshold select: 1 = resume level, 0 = detection level |
| ocp_mon_en | output | 1 | Overcurrent monitor power enable |
| ovc_mon_en | output | 1 | Overcharge monitor power enable |

## Verification
The bench targets the delay boundary by holding a low flag for one edge short of the delay and then for exactly the delay. A counter that is off by one would cut discharge early or late. It interrupts a low event and starts a new one on the other cell, which catches a counter that keeps stale counts. In sleep it raises a cell above the detection level but keeps it below the resume level; a design that kept the detection threshold would resume too early at that point. It also covers charger wake, charger removal while a cell is still low, and the case where resume and charger arrive together. A wrong priority in that last case would leave discharge off.

// File: rtl/odd_pkg.sv
package odd_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_ARM   = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } odd_state_e;

  typedef struct packed {
    logic dsg_en;
    logic pwr_down;
    logic thr_res;
    logic ocp_mon_en;
    logic ovc_forced;
  } odd_ctl_t;
endpackage

// File: rtl/odd_rst_sync.sv
module odd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/odd_cell_merge.sv
module odd_cell_merge #(
  parameter int NCELL = 2
) (
  input  logic [NCELL-1:0] lo_det,
  input  logic [NCELL-1:0] lo_res,
  input  logic [NCELL-1:0] hi_chg,
  output logic             det_any,
  output logic             res_clear,
  output logic             hi_any
);
  logic [NCELL:0] det_chain;
  logic [NCELL:0] res_chain;
  logic [NCELL:0] hi_chain;

  assign det_chain[0] = 1'b0;
  assign res_chain[0] = 1'b0;
  assign hi_chain[0]  = 1'b0;

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    assign det_chain[c+1] = det_chain[c] | lo_det[c];
    assign res_chain[c+1] = res_chain[c] | lo_res[c];
    assign hi_chain[c+1]  = hi_chain[c]  | hi_chg[c];
  end

  assign det_any   = det_chain[NCELL];
  assign res_clear = ~res_chain[NCELL];
  assign hi_any    = hi_chain[NCELL];
endmodule

// File: rtl/odd_delay.sv
module odd_delay #(
  parameter int DLY_CYCLES = 750000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic expired
);
  localparam int CW = $clog2(DLY_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DLY_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign expired = arm & at_last;
  assign cnt_en  = arm | (cnt_q != '0);

  always_comb begin
    if (!arm)         cnt_d = '0;
    else if (at_last) cnt_d = cnt_q;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/odd_fsm.sv
module odd_fsm
  import odd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       det_any,
  input  logic       res_clear,
  input  logic       chg,
  input  logic       dly_expired,
  output logic       dly_arm,
  output odd_state_e state
);
  odd_state_e state_q;
  odd_state_e state_d;

  assign dly_arm = det_any & ((state_q == ST_RUN) | (state_q == ST_ARM));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (det_any) state_d = ST_ARM;
      end
      ST_ARM: begin
        if (!det_any)         state_d = ST_RUN;
        else if (dly_expired) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (res_clear) state_d = ST_RUN;
        else if (chg)  state_d = ST_WAKE;
      end
      ST_WAKE: begin
        if (!det_any)  state_d = ST_RUN;
        else if (!chg) state_d = ST_SLEEP;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/odd_outdec.sv
module odd_outdec
  import odd_pkg::*;
(
  input  odd_state_e state,
  output odd_ctl_t   ctl
);
  always_comb begin
    ctl = '{dsg_en: 1'b1, pwr_down: 1'b0, thr_res: 1'b0,
            ocp_mon_en: 1'b1, ovc_forced: 1'b1};
    unique case (state)
      ST_RUN, ST_ARM: ;
      ST_SLEEP: begin
        ctl.dsg_en     = 1'b0;
        ctl.pwr_down   = 1'b1;
        ctl.thr_res    = 1'b1;
        ctl.ocp_mon_en = 1'b0;
        ctl.ovc_forced = 1'b0;
      end
      ST_WAKE: ctl.dsg_en = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/odd_guard.sv
module odd_guard
  import odd_pkg::*;
#(
  parameter int NCELL      = 2,
  parameter int DLY_CYCLES = 750000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] cell_lo_det,
  input  logic [NCELL-1:0] cell_lo_res,
  input  logic [NCELL-1:0] cell_hi_chg,
  input  logic             chg_present,
  output logic             dsg_en,
  output logic             pwr_down,
  output logic             thr_res,
  output logic             ocp_mon_en,
  output logic             ovc_mon_en
);
  logic       rst_core_n;
  logic       det_any;
  logic       res_clear;
  logic       hi_any;
  logic       dly_arm;
  logic       dly_expired;
  odd_state_e state;
  odd_ctl_t   ctl;

  odd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  odd_cell_merge #(.NCELL(NCELL)) u_merge (
    .lo_det    (cell_lo_det),
    .lo_res    (cell_lo_res),
    .hi_chg    (cell_hi_chg),
    .det_any   (det_any),
    .res_clear (res_clear),
    .hi_any    (hi_any)
  );

  odd_delay #(.DLY_CYCLES(DLY_CYCLES)) u_dly (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .arm     (dly_arm),
    .expired (dly_expired)
  );

  odd_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .det_any     (det_any),
    .res_clear   (res_clear),
    .chg         (chg_present),
    .dly_expired (dly_expired),
    .dly_arm     (dly_arm),
    .state       (state)
  );

  odd_outdec u_dec (
    .state (state),
    .ctl   (ctl)
  );

  assign dsg_en     = ctl.dsg_en;
  assign pwr_down   = ctl.pwr_down;
  assign thr_res    = ctl.thr_res;
  assign ocp_mon_en = ctl.ocp_mon_en;
  assign ovc_mon_en = ctl.ovc_forced | hi_any;
endmodule

// File: rtl/odd_guard_chk.sv
module odd_guard_chk #(
  parameter int NCELL      = 2,
  parameter int DLY_CYCLES = 750000
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCELL-1:0] cell_lo_det,
  input logic [NCELL-1:0] cell_lo_res,
  input logic [NCELL-1:0] cell_hi_chg,
  input logic             chg_present,
  input logic             dsg_en,
  input logic             pwr_down,
  input logic             thr_res,
  input logic             ocp_mon_en,
  input logic             ovc_mon_en
);
  localparam int CW = $clog2(DLY_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(DLY_CYCLES);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (!(|cell_lo_det))  run_q <= '0;
    else if (run_q != FULL)    run_q <= run_q + CW'(1);
  end

  a_r2_full_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dsg_en) |-> (run_q == FULL));

  a_r3_cancel_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (dsg_en && !(|cell_lo_det)) |=> dsg_en);

  a_r4_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!dsg_en && thr_res && !ocp_mon_en));

  a_r5_ovc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (ovc_mon_en == (|cell_hi_chg)));

  a_r6_stay_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && (|cell_lo_res)) |=> !dsg_en);

  a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down && chg_present && (|cell_lo_res)) |=> (!pwr_down && !thr_res && ocp_mon_en));

  a_r8_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_down && !dsg_en && chg_present && (|cell_lo_det)) |=> !dsg_en);
endmodule

bind odd_guard odd_guard_chk #(.NCELL(NCELL), .DLY_CYCLES(DLY_CYCLES)) u_chk (.*);

// File: tb/sim_odd_guard.sv
module sim_odd_guard;
  localparam int NC  = 2;
  localparam int DLY = 6;
  localparam int M_RUN = 0, M_SLP = 1, M_WAKE = 2;

  typedef struct {
    int    mode;
    logic  ovc;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [NC-1:0] lo_det, lo_res, hi_chg;
  logic chg;
  logic dsg_en, pwr_down, thr_res, ocp_mon_en, ovc_mon_en;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  exp_t cur;

  always #10 clk = ~clk;

  odd_guard #(.NCELL(NC), .DLY_CYCLES(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .cell_lo_det(lo_det), .cell_lo_res(lo_res),
    .cell_hi_chg(hi_chg), .chg_present(chg), .dsg_en(dsg_en),
    .pwr_down(pwr_down), .thr_res(thr_res), .ocp_mon_en(ocp_mon_en),
    .ovc_mon_en(ovc_mon_en)
  );

  function automatic logic [4:0] expect_vec(int mode, logic ovc);
    case (mode)
      M_SLP:   return {4'b0110, ovc};
      M_WAKE:  return 5'b00011;
      default: return 5'b10011;
    endcase
  endfunction

  task automatic compare(logic [4:0] exp_v, string tag);
    logic [4:0] act;
    act = {dsg_en, pwr_down, thr_res, ocp_mon_en, ovc_mon_en};
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s act=%b exp=%b (dsg,pd,thr,ocp,ovc)", tag, act, exp_v);
    end
  endtask

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      cur = q.pop_front();
      compare(expect_vec(cur.mode, cur.ovc), cur.tag);
    end
  end

  task automatic step(logic [NC-1:0] d, logic [NC-1:0] r, logic c,
                      logic [NC-1:0] h, int mode, string tag);
    exp_t e;
    @(negedge clk);
    lo_det = d; lo_res = r; chg = c; hi_chg = h;
    e.mode = mode; e.ovc = |h; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic hold(int n, logic [NC-1:0] d, logic [NC-1:0] r, logic c,
                      logic [NC-1:0] h, int mode, string tag);
    for (int i = 0; i < n; i++) step(d, r, c, h, mode, tag);
  endtask

  // full low event: DLY-1 edges still running, sleep after the DLY-th
  task automatic low_event(logic [NC-1:0] d, string tag);
    for (int i = 1; i <= DLY; i++)
      step(d, d, 1'b0, 2'b00, (i < DLY) ? M_RUN : M_SLP, tag);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; lo_det = '0; lo_res = '0; hi_chg = '0; chg = 1'b0;
    repeat (3) @(negedge clk);
    compare(5'b10011, "R1 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare(5'b10011, "R1 after release");

    // R9: resume flags, charger and overcharge ignored in normal operation
    hold(3, 2'b00, 2'b11, 1'b1, 2'b11, M_RUN, "R9 ignored inputs");

    // R3: interrupted low events leave discharge on
    hold(DLY-1, 2'b01, 2'b01, 1'b0, 2'b00, M_RUN, "R3 short low cell0");
    step(2'b00, 2'b00, 1'b0, 2'b00, M_RUN, "R3 cancel");
    hold(DLY-1, 2'b10, 2'b10, 1'b0, 2'b00, M_RUN, "R3 restart full count");
    step(2'b00, 2'b00, 1'b0, 2'b00, M_RUN, "R3 cancel again");

    // R2, R10: cell 1 alone, exact delay boundary
    low_event(2'b10, "R2 R10 cell1 delay");

    // R4, R5: sleep outputs with and without overcharge
    hold(2, 2'b10, 2'b10, 1'b0, 2'b01, M_SLP, "R5 ovc kept powered");
    hold(2, 2'b10, 2'b10, 1'b0, 2'b00, M_SLP, "R4 sleep outputs");

    // R6: above detection but below resume keeps sleep
    hold(3, 2'b00, 2'b10, 1'b0, 2'b00, M_SLP, "R6 resume level held");
    step(2'b00, 2'b00, 1'b0, 2'b00, M_RUN, "R6 resume restores");

    // R10: cell 0 alone
    low_event(2'b01, "R10 cell0 delay");

    // R7, R8: charger wake, removal, wake again, restore at detection level
    step(2'b01, 2'b01, 1'b1, 2'b00, M_WAKE, "R7 charger wake");
    hold(2, 2'b01, 2'b01, 1'b1, 2'b00, M_WAKE, "R8 wake holds");
    step(2'b01, 2'b01, 1'b0, 2'b00, M_SLP, "R8 charger gone");
    step(2'b01, 2'b01, 1'b1, 2'b00, M_WAKE, "R7 wake again");
    step(2'b00, 2'b01, 1'b1, 2'b00, M_RUN, "R8 detection level restores");
    hold(2, 2'b00, 2'b01, 1'b0, 2'b00, M_RUN, "R9 resume flag ignored");

    // R11: resume and charger together
    low_event(2'b11, "R2 both cells");
    step(2'b00, 2'b00, 1'b1, 2'b00, M_RUN, "R11 resume over charger");
    hold(2, 2'b00, 2'b00, 1'b0, 2'b00, M_RUN, "R1 steady run");

    repeat (3) @(posedge clk);
    #6;
    summary();
  end
endmodule